// File: doc/BRIEF.md
# First-Come Two-Way Interlock

This block settles a race between two requesters inside a clocked design. Two request lines, `req_a` and `req_b`, may come from unrelated timing domains. Each passes through its own synchronizer chain, whose depth is a parameter. A small decision register then watches the last stage of both chains. The first request that it sees high wins the interlock. The matching grant (`grant_x` for A, `grant_y` for B) rises and stays high until the surrounding logic pulses `clear`.

The decision is one-shot. After a side has won, the other grant cannot rise during that epoch, even if its request arrives later. A grant cannot fall because its own request drops. Both grants come straight from flip-flops, so they never glitch.

The block may see both requests for the first time on the same clock edge. It still names a single winner, and a tie rule decides which one. The tie rule is either a fixed favoured side or a rotating bit that inverts with every clear. Fairness between the sides matters less than having a single, stable winner.

Top module: `first_come_interlock`

## Requirements
- R1: After `rst_n` is released, `grant_x` and `grant_y` are both low and stay low while neither request has been sampled high.
- R2: If `req_a` is sampled high on an earlier clock edge than `req_b`, then `grant_x` rises. It rises exactly SYNC_DEPTH+1 rising edges after the first edge that sampled `req_a` high, counting that edge as the first.
- R3: If `req_b` is sampled high on an earlier clock edge than `req_a`, then `grant_y` rises with the same latency as in R2.
- R4: Once either grant is high, the other grant stays low until `clear`, whatever its request does.
- R5: A high grant stays high on every edge where `clear` is low. An edge with `clear` high leaves both grants low after it.
- R6: `grant_x` and `grant_y` are never high at the same time.
- R7: With TIE_ROTATE=0, requests first sampled high on the same edge go to B when FIXED_FAVOR_B=1, and to A when FIXED_FAVOR_B=0.
- R8: With TIE_ROTATE=1, a same-edge tie goes to the side held in a turn bit. A turn value of 1 means B. The bit starts at FIXED_FAVOR_B after reset and inverts on every edge where `clear` is high.
- R9: A request pulse that no clock edge samples leaves the block waiting. A later request on the other side then wins.
- R10: A request that falls after its grant has risen does not lower the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchronizers and the decision register |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous end of epoch: releases any grant |
| req_a | input | 1 | Request from side A, may be asynchronous |
| req_b | input | 1 | Request from side B, may be asynchronous |
| grant_x | output | 1 | Registered grant to side A |
| grant_y | output | 1 | Registered grant to side B |

## Verification
The bench builds two copies of the block, and both see the same stimulus. The first copy has SYNC_DEPTH=2, a fixed tie rule and A favoured. The second has SYNC_DEPTH=3, the rotating tie rule and B favoured at first. Every same-edge tie therefore checks both tie variants at once: one copy resolves it by the fixed rule and the other by the current turn, which changes with each clear. The two chain depths show that the grant latency follows the parameter. Random arrival offsets of 0 to 4 cycles produce staggered and same-edge arrivals often. Directed epochs add an unsampled glitch, a lone request and an epoch with no request.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
   // Decision state: bit 0 is the A-side grant, bit 1 is the B-side grant.
   typedef enum logic [1:0] {
      ST_WAIT  = 2'b00,
      ST_WON_A = 2'b01,
      ST_WON_B = 2'b10
   } dec_t;

   localparam int unsigned MIN_SYNC_DEPTH = 2;
   localparam int unsigned MAX_SYNC_DEPTH = 8;
endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_in;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_out = chain_q[LAST];
endmodule

// File: rtl/ilk_tie.sv
module ilk_tie #(
   parameter bit TIE_ROTATE    = 1'b0,
   parameter bit FIXED_FAVOR_B = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic pick_b
);
   if (TIE_ROTATE) begin : g_rotate
      logic turn_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     turn_q <= FIXED_FAVOR_B;
         else if (clear) turn_q <= ~turn_q;
      end
      assign pick_b = turn_q;
   end else begin : g_fixed
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ clear;
      assign pick_b    = FIXED_FAVOR_B;
   end
endmodule

// File: rtl/ilk_decide.sv
module ilk_decide
   import ilk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic seen_a,
   input  logic seen_b,
   input  logic pick_b,
   output logic win_a,
   output logic win_b
);
   dec_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (clear) begin
         state_d = ST_WAIT;
      end else if (state_q == ST_WAIT) begin
         unique case ({seen_b, seen_a})
            2'b01:   state_d = ST_WON_A;
            2'b10:   state_d = ST_WON_B;
            2'b11:   state_d = pick_b ? ST_WON_B : ST_WON_A;
            default: state_d = ST_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_WAIT;
      else        state_q <= state_d;
   end

   assign win_a = state_q[0];
   assign win_b = state_q[1];
endmodule

// File: rtl/first_come_interlock.sv
module first_come_interlock
   import ilk_pkg::*;
#(
   parameter int unsigned SYNC_DEPTH    = 2,
   parameter bit          TIE_ROTATE    = 1'b0,
   parameter bit          FIXED_FAVOR_B = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic req_a,
   input  logic req_b,
   output logic grant_x,
   output logic grant_y
);
   if (SYNC_DEPTH < MIN_SYNC_DEPTH) begin : g_chk_min
      $error("first_come_interlock: SYNC_DEPTH below minimum");
   end
   if (SYNC_DEPTH > MAX_SYNC_DEPTH) begin : g_chk_max
      $error("first_come_interlock: SYNC_DEPTH above maximum");
   end

   logic sync_a, sync_b, pick_b;

   ilk_sync #(.STAGES(SYNC_DEPTH)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .d_in(req_a), .q_out(sync_a));
   ilk_sync #(.STAGES(SYNC_DEPTH)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .d_in(req_b), .q_out(sync_b));

   ilk_tie #(.TIE_ROTATE(TIE_ROTATE), .FIXED_FAVOR_B(FIXED_FAVOR_B)) u_tie (
      .clk(clk), .rst_n(rst_n), .clear(clear), .pick_b(pick_b));

   ilk_decide u_decide (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .seen_a(sync_a), .seen_b(sync_b), .pick_b(pick_b),
      .win_a(grant_x), .win_b(grant_y));
endmodule

// File: rtl/ilk_checker.sv
module ilk_checker (
   input logic clk,
   input logic rst_n,
   input logic clear,
   input logic sa,
   input logic sb,
   input logic gx,
   input logic gy
);
   // R6: the two grants are never high together
   p_mutex_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(gx && gy));
   // R5: a grant holds while clear is low
   p_hold_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gx && !clear |=> gx);
   p_hold_y_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gy && !clear |=> gy);
   // R5: an edge with clear high releases both grants
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !gx && !gy);
   // R4: the losing side stays out
   p_lock_x_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gx && !clear |=> !gy);
   p_lock_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gy && !clear |=> !gx);
   // R2: A seen alone while waiting wins
   p_first_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !gx && !gy && sa && !sb && !clear |=> gx);
   // R3: B seen alone while waiting wins
   p_first_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !gx && !gy && sb && !sa && !clear |=> gy);
   // R7: a same-edge tie still yields exactly one winner
   p_tie_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !gx && !gy && sa && sb && !clear |=> $countones({gx, gy}) == 1);
   // R9: with no request seen, the block keeps waiting
   p_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !gx && !gy && !sa && !sb |=> !gx && !gy);
   // R10: a dropped request does not release its grant
   p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      gx && !sa && !clear |=> gx);
endmodule

bind first_come_interlock ilk_checker u_ilk_checker (
   .clk(clk), .rst_n(rst_n), .clear(clear),
   .sa(sync_a), .sb(sync_b), .gx(grant_x), .gy(grant_y));

// File: tb/first_come_interlock_tb.sv
module first_come_interlock_tb;
   localparam int CLK_PERIOD = 10;
   localparam int D_FIX = 2;
   localparam int D_ROT = 3;
   localparam int EPOCH_CYCLES = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear = 1'b0;
   logic req_a = 1'b0;
   logic req_b = 1'b0;
   logic gx_f, gy_f, gx_r, gy_r;
   int   n_checks = 0;
   int   n_fail = 0;
   bit   turn_b = 1'b1;   // bench copy of the rotating turn, starts at favour B

   always #(CLK_PERIOD/2) clk = ~clk;

   first_come_interlock #(.SYNC_DEPTH(D_FIX), .TIE_ROTATE(1'b0), .FIXED_FAVOR_B(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .req_a(req_a), .req_b(req_b),
      .grant_x(gx_f), .grant_y(gy_f));
   first_come_interlock #(.SYNC_DEPTH(D_ROT), .TIE_ROTATE(1'b1), .FIXED_FAVOR_B(1'b1)) u_dut_rot (
      .clk(clk), .rst_n(rst_n), .clear(clear), .req_a(req_a), .req_b(req_b),
      .grant_x(gx_r), .grant_y(gy_r));

   task automatic check(string req, logic [1:0] act, logic [1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: grants {y,x} actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Expected {grant_y, grant_x} on sample n of an epoch.
   function automatic logic [1:0] exp_grant(int ta, int tb, bit ea, bit eb,
                                            int n, int d, bit tie_b);
      logic [1:0] w;
      int first;
      if (!ea && !eb) return 2'b00;
      if (ea && (!eb || ta < tb))      begin w = 2'b01; first = ta; end
      else if (eb && (!ea || tb < ta)) begin w = 2'b10; first = tb; end
      else begin w = tie_b ? 2'b10 : 2'b01; first = ta; end
      return (n >= first + d + 1) ? w : 2'b00;
   endfunction

   function automatic string tag_for(int ta, int tb, bit ea, bit eb, bit rot,
                                     int n, int d, bit glitch, int stop);
      int first;
      if (!ea && !eb) return glitch ? "R9" : "R1";
      first = (ea && eb) ? ((ta < tb) ? ta : tb) : (ea ? ta : tb);
      if (n < first + d + 1) return glitch ? "R9" : "R1";
      if (n == first + d + 1) begin
         if (ea && eb && ta == tb) return rot ? "R8" : "R7";
         if (ea && (!eb || ta < tb)) return "R2";
         return "R3";
      end
      if (n >= stop) return "R10";
      return "R4";
   endfunction

   task automatic run_epoch(int ta, int tb, bit ea, bit eb, int la, int lb, bit glitch);
      int stop_a, stop_b, stop;
      stop_a = ta + la;
      stop_b = tb + lb;
      stop = (ea && stop_a > stop_b) ? stop_a : stop_b;
      for (int n = 0; n < EPOCH_CYCLES; n++) begin
         @(negedge clk);
         check(tag_for(ta, tb, ea, eb, 1'b0, n, D_FIX, glitch, stop), {gy_f, gx_f},
               exp_grant(ta, tb, ea, eb, n, D_FIX, 1'b0));
         check(tag_for(ta, tb, ea, eb, 1'b1, n, D_ROT, glitch, stop), {gy_r, gx_r},
               exp_grant(ta, tb, ea, eb, n, D_ROT, turn_b));
         if (gx_f && gy_f) check("R6", 2'b11, 2'b01);
         req_a = ea && (n >= ta) && (n < stop_a);
         req_b = eb && (n >= tb) && (n < stop_b);
         if (glitch && n == 0) begin
            #1 req_a = 1'b1;
            #1 req_a = 1'b0;
         end
      end
      @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      turn_b = ~turn_b;
      check("R5", {gy_f, gx_f}, 2'b00);
      check("R5", {gy_r, gx_r}, 2'b00);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      check("R1", {gy_f, gx_f}, 2'b00);
      check("R1", {gy_r, gx_r}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {gy_f, gx_f}, 2'b00);
      check("R1", {gy_r, gx_r}, 2'b00);

      run_epoch(0, 0, 1'b0, 1'b0, 1, 1, 1'b0);  // R1: idle epoch
      run_epoch(1, 3, 1'b1, 1'b1, 6, 6, 1'b0);  // R2: A first
      run_epoch(4, 2, 1'b1, 1'b1, 6, 6, 1'b0);  // R3: B first
      run_epoch(2, 2, 1'b1, 1'b1, 5, 5, 1'b0);  // R7 / R8 tie
      run_epoch(2, 2, 1'b1, 1'b1, 5, 5, 1'b0);  // R8: turn flipped
      run_epoch(0, 3, 1'b0, 1'b1, 1, 4, 1'b1);  // R9: glitch on A, B wins
      run_epoch(0, 1, 1'b1, 1'b1, 1, 8, 1'b0);  // R10: A drops at once
      run_epoch(0, 0, 1'b0, 1'b1, 1, 2, 1'b0);  // R3: B alone

      for (int e = 0; e < 60; e++) begin
         run_epoch(int'($urandom_range(4, 0)), int'($urandom_range(4, 0)),
                   ($urandom_range(3, 0) != 0), ($urandom_range(3, 0) != 0),
                   int'($urandom_range(6, 1)), int'($urandom_range(6, 1)), 1'b0);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule